// File: doc/BRIEF.md
# Averaging Conversion Timing Sequencer

This block runs one logical analog-to-digital conversion from its start pulse to its done pulse. A logical conversion is one sample or a hardware-averaged group of 4, 8, 16 or 32 samples. The block makes a converter-clock enable from the bus clock through a selectable divider. It counts a fixed overhead of converter-clock ticks, then a fixed number of ticks for each sample. It also tells a converter stub when each sample is taken, sums the samples, and outputs their truncated mean together with a one-cycle done pulse.

The caller sets the divider, the extra halving of the bus clock, the averaging enable and the 2-bit averaging select, then pulses start. The block latches the configuration at an accepted start. It ignores start while a conversion is in flight.

Top module: `avg_conv_seq`

## Requirements
- R1: A conversion lasts T = 6 + N x 28 converter-clock ticks, which is a 6-tick overhead plus 25 base and 3 long-sample ticks per sample. With a divide of D bus cycles per tick, conv_done is high in the bus cycle that starts T x D clock edges after the edge that samples start.
- R2: With avg_enable = 0, N = 1 whatever avg_count_sel holds. With avg_enable = 1, avg_count_sel 00, 01, 10 and 11 give N = 4, 8, 16 and 32.
- R3: clk_div_sel 00, 01, 10 and 11 divide by 1, 2, 4 and 8. bus_half_sel = 1 doubles that divide, so clk_div_sel = 11 with bus_half_sel = 1 divides by 16.
- R4: mean_out is the sum of the N samples shifted right by log2(N), with the remainder dropped.
- R5: The sum holds 32 samples of 4095 without overflow, so the mean of such a group is 4095.
- R6: conv_done stays high for exactly one cycle. mean_out changes only in the cycle where conv_done is high and holds until the next conv_done.
- R7: A start pulse that arrives while a conversion is in flight has no effect. It gives no extra conv_done and does not change the timing.
- R8: The configuration inputs are latched at the accepted start. Changes during a conversion do not affect its timing or its N.
- R9: sample_take is high for one bus cycle on the last tick of each sample's 28 ticks, so there are exactly N pulses per conversion. sample_in is captured on that cycle's closing edge, and conv_done follows the last pulse.
- R10: While reset is held and after it is released, conv_done, sample_take and mean_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a conversion when the block is idle |
| clk_div_sel | input | 2 | Converter-clock divide: 1, 2, 4, 8 |
| bus_half_sel | input | 1 | Extra divide by 2 of the bus clock |
| avg_enable | input | 1 | Hardware averaging enable |
| avg_count_sel | input | 2 | Averaging count select: 4, 8, 16, 32 |
| sample_in | input | 12 | Sample value from the converter stub |
| sample_take | output | 1 | Sample captured at the end of this cycle |
| mean_out | output | 12 | Averaged result |
| conv_done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 12-bit samples, a 6-tick overhead, 25 plus 3 ticks per sample, at most 32 samples, and a prescaler that reaches a divide by 16. With these values a full-scale group of 32 samples reaches the top of the 17-bit sum, so the no-overflow case can be tested. The slowest setting, 32 samples at a divide of 16, takes 14432 bus cycles and still fits in the run. That lets the bench check the exact done cycle for every divider and every averaging count.

// File: rtl/avg_seq_pkg.sv
package avg_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OVH  = 2'd1,
        ST_SMP  = 2'd2
    } seq_state_e;

    // log2 of the averaged sample count
    function automatic logic [2:0] avg_log2(input logic en, input logic [1:0] sel);
        return en ? (3'd2 + {1'b0, sel}) : 3'd0;
    endfunction

    // log2 of the bus cycles per converter tick
    function automatic logic [2:0] div_log2(input logic [1:0] sel, input logic half);
        return {1'b0, sel} + {2'b00, half};
    endfunction

endpackage

// File: rtl/avg_tick_gen.sv
module avg_tick_gen #(
    parameter int MAX_DIV_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] div_shift,
    output logic       tick
);
    localparam int CNT_W = (MAX_DIV_LOG2 > 0) ? MAX_DIV_LOG2 : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_s;

    tick_s      st_d, st_q;
    logic [CNT_W:0] limit;

    always_comb begin
        limit = ((CNT_W+1)'(1) << div_shift) - (CNT_W+1)'(1);
        tick  = run && ({1'b0, st_q.cnt} == limit);
        st_d  = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/avg_seq_ctrl.sv
module avg_seq_ctrl
    import avg_seq_pkg::*;
#(
    parameter int OVH_TICKS    = 6,
    parameter int SMP_TICKS    = 28,
    parameter int MAX_AVG_LOG2 = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tick,
    input  logic [2:0] div_shift_in,
    input  logic [2:0] avg_shift_in,
    output logic       busy,
    output logic [2:0] div_shift,
    output logic [2:0] avg_shift,
    output logic       acc_clear,
    output logic       take,
    output logic       last,
    output logic       done
);
    localparam int PH_MAX = (OVH_TICKS > SMP_TICKS) ? OVH_TICKS : SMP_TICKS;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int IDX_W  = MAX_AVG_LOG2 + 1;

    typedef struct packed {
        seq_state_e       state;
        logic [PH_W-1:0]  ph_cnt;
        logic [IDX_W-1:0] smp_idx;
        logic [2:0]       div_shift;
        logic [2:0]       avg_shift;
        logic             done;
    } ctrl_s;

    ctrl_s            st_d, st_q;
    logic [IDX_W-1:0] last_idx;
    logic             accept;
    logic             ph_end;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        last_idx  = (IDX_W'(1) << st_q.avg_shift) - IDX_W'(1);
        accept    = start && (st_q.state == ST_IDLE);
        ph_end    = 1'b0;
        take      = 1'b0;
        last      = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (accept) begin
                    st_d.state     = ST_OVH;
                    st_d.ph_cnt    = '0;
                    st_d.smp_idx   = '0;
                    st_d.div_shift = div_shift_in;
                    st_d.avg_shift = avg_shift_in;
                end
            end
            ST_OVH: begin
                if (tick) begin
                    ph_end = (st_q.ph_cnt == PH_W'(OVH_TICKS - 1));
                    if (ph_end) begin
                        st_d.state  = ST_SMP;
                        st_d.ph_cnt = '0;
                    end else begin
                        st_d.ph_cnt = st_q.ph_cnt + PH_W'(1);
                    end
                end
            end
            ST_SMP: begin
                if (tick) begin
                    ph_end = (st_q.ph_cnt == PH_W'(SMP_TICKS - 1));
                    if (ph_end) begin
                        take        = 1'b1;
                        st_d.ph_cnt = '0;
                        if (st_q.smp_idx == last_idx) begin
                            last       = 1'b1;
                            st_d.state = ST_IDLE;
                            st_d.done  = 1'b1;
                        end else begin
                            st_d.smp_idx = st_q.smp_idx + IDX_W'(1);
                        end
                    end else begin
                        st_d.ph_cnt = st_q.ph_cnt + PH_W'(1);
                    end
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.state != ST_IDLE);
    assign div_shift = st_q.div_shift;
    assign avg_shift = st_q.avg_shift;
    assign acc_clear = accept;
    assign done      = st_q.done;
endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
    parameter int SAMPLE_W     = 12,
    parameter int MAX_AVG_LOG2 = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                take,
    input  logic                last,
    input  logic [2:0]          shift,
    input  logic [SAMPLE_W-1:0] data,
    output logic [SAMPLE_W-1:0] mean
);
    localparam int ACC_W = SAMPLE_W + MAX_AVG_LOG2;

    typedef struct packed {
        logic [ACC_W-1:0]    acc;
        logic [SAMPLE_W-1:0] res;
    } acc_s;

    acc_s             st_d, st_q;
    logic [ACC_W-1:0] sum_now;

    always_comb begin
        st_d    = st_q;
        sum_now = st_q.acc + ACC_W'(data);
        if (clear) begin
            st_d.acc = '0;
        end else if (take) begin
            st_d.acc = sum_now;
        end
        if (take && last) begin
            st_d.res = SAMPLE_W'(sum_now >> shift);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mean = st_q.res;
endmodule

// File: rtl/avg_conv_seq.sv
module avg_conv_seq
    import avg_seq_pkg::*;
#(
    parameter int SAMPLE_W     = 12,
    parameter int OVH_TICKS    = 6,
    parameter int BASE_TICKS   = 25,
    parameter int LONG_TICKS   = 3,
    parameter int MAX_AVG_LOG2 = 5,
    parameter int MAX_DIV_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          clk_div_sel,
    input  logic                bus_half_sel,
    input  logic                avg_enable,
    input  logic [1:0]          avg_count_sel,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                sample_take,
    output logic [SAMPLE_W-1:0] mean_out,
    output logic                conv_done
);
    localparam int SMP_TICKS = BASE_TICKS + LONG_TICKS;

    logic       busy;
    logic       tick;
    logic [2:0] div_shift;
    logic [2:0] avg_shift;
    logic       acc_clear;
    logic       last;

    avg_tick_gen #(
        .MAX_DIV_LOG2(MAX_DIV_LOG2)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div_shift(div_shift),
        .tick     (tick)
    );

    avg_seq_ctrl #(
        .OVH_TICKS   (OVH_TICKS),
        .SMP_TICKS   (SMP_TICKS),
        .MAX_AVG_LOG2(MAX_AVG_LOG2)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .tick        (tick),
        .div_shift_in(div_log2(clk_div_sel, bus_half_sel)),
        .avg_shift_in(avg_log2(avg_enable, avg_count_sel)),
        .busy        (busy),
        .div_shift   (div_shift),
        .avg_shift   (avg_shift),
        .acc_clear   (acc_clear),
        .take        (sample_take),
        .last        (last),
        .done        (conv_done)
    );

    avg_accum #(
        .SAMPLE_W    (SAMPLE_W),
        .MAX_AVG_LOG2(MAX_AVG_LOG2)
    ) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(acc_clear),
        .take (sample_take),
        .last (last),
        .shift(avg_shift),
        .data (sample_in),
        .mean (mean_out)
    );
endmodule

// File: rtl/avg_conv_seq_chk.sv
module avg_conv_seq_chk #(
    parameter int SAMPLE_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                sample_take,
    input logic                conv_done,
    input logic [SAMPLE_W-1:0] mean_out,
    input logic [2:0]          avg_shift
);
    logic [6:0] take_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_cnt <= '0;
        end else if (start && !busy) begin
            take_cnt <= '0;
        end else if (sample_take) begin
            take_cnt <= take_cnt + 7'd1;
        end
    end

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    a_r6_mean_held: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |-> $stable(mean_out));

    a_r9_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> $past(sample_take));

    a_r9_take_count: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (take_cnt == (7'd1 << avg_shift)));

    a_r7_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !sample_take) |=> busy);

    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sample_take);
endmodule

bind avg_conv_seq avg_conv_seq_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .sample_take(sample_take),
    .conv_done  (conv_done),
    .mean_out   (mean_out),
    .avg_shift  (avg_shift)
);

// File: tb/test_avg_conv_seq.sv
`timescale 1ns/1ps
module test_avg_conv_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  clk_div_sel = '0;
    logic        bus_half_sel = 1'b0;
    logic        avg_enable = 1'b0;
    logic [1:0]  avg_count_sel = '0;
    logic [11:0] sample_in;
    logic        sample_take;
    logic [11:0] mean_out;
    logic        conv_done;

    always #2 clk = ~clk;

    avg_conv_seq i_avg_conv_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_div_sel(clk_div_sel),
        .bus_half_sel(bus_half_sel), .avg_enable(avg_enable),
        .avg_count_sel(avg_count_sel), .sample_in(sample_in),
        .sample_take(sample_take), .mean_out(mean_out), .conv_done(conv_done)
    );

    typedef struct {
        int    res;
        int    cyc;
        int    n;
        string req;
    } exp_t;

    exp_t        sb[$];
    logic [11:0] vals [32];
    int          idx = 0;
    int          cyc = 0;
    int          checks = 0;
    int          failures = 0;
    int          takes = 0;
    logic        chk_after = 1'b0;
    logic [11:0] last_mean = '0;
    logic        finished = 1'b0;

    assign sample_in = vals[(idx > 31) ? 31 : idx];

    task automatic check(input string req, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // converter stub: next value after each taken sample
    initial forever begin
        @(negedge clk);
        if (sample_take) begin
            @(posedge clk);
            #1 idx++;
        end
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (chk_after) begin
            chk_after = 1'b0;
            check("R6", int'(conv_done), 0, "done width");
            check("R6", int'(mean_out), int'(last_mean), "mean held");
        end
        if (sample_take) takes++;
        if (conv_done) begin
            if (sb.size() == 0) begin
                check("R7", 1, 0, "unexpected done");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, cyc, e.cyc, "done cycle");
                check("R4", int'(mean_out), e.res, "mean");
                check("R9", takes, e.n, "take pulses");
                last_mean = mean_out;
                chk_after = 1'b1;
            end
            takes = 0;
        end
        if (cyc > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            report();
        end
    end

    function automatic int n_of(input logic en, input logic [1:0] sel);
        return en ? (4 << sel) : 1;
    endfunction

    function automatic int lg(input int n);
        int r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    // sets config, fills samples, pushes expectation, pulses start
    task automatic launch(input logic [1:0] dsel, input logic half, input logic en,
                          input logic [1:0] asel, input int base, input int step,
                          input string req);
        exp_t e;
        int   n, d, sum;
        @(negedge clk);
        clk_div_sel = dsel; bus_half_sel = half; avg_enable = en; avg_count_sel = asel;
        n   = n_of(en, asel);
        d   = (1 << dsel) * (half ? 2 : 1);
        sum = 0;
        for (int i = 0; i < 32; i++) begin
            vals[i] = 12'((base + i * step) & 12'hFFF);
            if (i < n) sum += int'(vals[i]);
        end
        idx   = 0;
        e.res = sum >> lg(n);
        e.cyc = cyc + 1 + (6 + 28 * n) * d;
        e.n   = n;
        e.req = req;
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) vals[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", int'(conv_done), 0, "done in reset");
        check("R10", int'(mean_out), 0, "mean in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", int'(sample_take), 0, "take after reset");
        check("R10", int'(conv_done), 0, "done after reset");

        // R1: single sample, divide by 1
        launch(2'd0, 1'b0, 1'b0, 2'd0, 12'hABC, 0, "R1"); drain();
        // R3: divider sweep
        launch(2'd1, 1'b0, 1'b0, 2'd0, 100, 0, "R3"); drain();
        launch(2'd2, 1'b0, 1'b0, 2'd0, 200, 0, "R3"); drain();
        launch(2'd3, 1'b0, 1'b0, 2'd0, 300, 0, "R3"); drain();
        launch(2'd0, 1'b1, 1'b0, 2'd0, 400, 0, "R3"); drain();
        launch(2'd3, 1'b1, 1'b0, 2'd0, 500, 0, "R3"); drain();
        // R2: select ignored when averaging off, then each count
        launch(2'd0, 1'b0, 1'b0, 2'd3, 77, 5, "R2"); drain();
        launch(2'd0, 1'b0, 1'b1, 2'd0, 10, 7, "R2"); drain();
        launch(2'd0, 1'b0, 1'b1, 2'd1, 1000, 13, "R2"); drain();
        launch(2'd1, 1'b0, 1'b1, 2'd2, 3000, 61, "R2"); drain();
        launch(2'd0, 1'b0, 1'b1, 2'd3, 5, 129, "R2"); drain();
        // R4: truncation (1,2,3,4 -> 10/4 = 2)
        launch(2'd0, 1'b0, 1'b1, 2'd0, 1, 1, "R4"); drain();
        // R5: full-scale 32-sample sum
        launch(2'd0, 1'b0, 1'b1, 2'd3, 4095, 0, "R5"); drain();
        // slowest setting
        launch(2'd3, 1'b1, 1'b1, 2'd3, 2048, 1, "R1"); drain();

        // R7 and R8: start again and change config mid-run
        launch(2'd1, 1'b0, 1'b1, 2'd0, 60, 3, "R8");
        repeat (20) @(negedge clk);
        clk_div_sel = 2'd3; avg_count_sel = 2'd3; bus_half_sel = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        repeat (200) @(negedge clk);
        check("R7", sb.size(), 0, "no pending expectation");

        report();
    end
endmodule